// File: doc/BRIEF.md
# Frame Delay Response Timer

The block is a carrier-paced up-counter that times the gap between the end of a reader's modulation pause and the instant a card emulator must begin its synchronous reply. The demodulated receive line passes through a synchronizer. Its falling edge marks the end of a pause, and on that edge the count returns to zero and a new timing run begins. The counter then advances once per carrier tick. Three programmable compare values act on the run. Reaching the first one raises the transmit-frame level, whose rising edge is the hardware start for the reply. Reaching the second one records the end of the incoming frame. Reaching the third one lowers the transmit-frame level and halts the counter, which stays halted until the next trigger.

Behaviour is built around a two-state machine. `ST_STOP` holds the count. It is entered at reset and by the transition *limit reached*, which happens when the count reaches the third compare value. `ST_RUN` advances the count. It is entered by the transition *trigger restart*, taken from either state. A small register port sets the compare values, a global count enable and per-event interrupt enables. It also exposes four sticky event flags, which clear when read, and the live count. The interrupt line is the OR of the enabled flags.

Register map (word addresses): 0 = control (bit 0 = count enable, reset 0), 1 = compare A (reset 0), 2 = compare B (reset 256), 3 = compare C (reset 0xFFFF), 4 = interrupt enables in bits 3:0, 5 = status (read clears), 6 = current count (read-only). In the status and enable registers, bit 0 is trigger seen, bit 1 is compare A match, bit 2 is compare B match and bit 3 is compare C match.

Top module: `frame_delay_timer`

## Requirements
- R1: After reset the count is 0, the state is `ST_STOP`, `tx_frame` and `irq` are low, status reads 0, compare B reads 256 and compare C reads 0xFFFF.
- R2: While in `ST_RUN` with counting enabled, the count rises by exactly one on each cycle where `carrier_tick` is high, and it holds on cycles where `carrier_tick` is low.
- R3: A falling edge on `rx_data_in` reaches the counter three clock edges after it is applied: two synchronizer flops and then one counter update. It sets the count to 0, enters `ST_RUN` and sets status bit 0. A rising edge has no effect.
- R4: `tx_frame` goes high on the edge at which the count becomes equal to compare A.
- R5: `tx_frame` goes low on the edge at which the count becomes equal to compare C, and on every accepted trigger. If A equals C, the clear wins.
- R6: When the count becomes equal to compare C, the counter takes the *limit reached* transition to `ST_STOP`. It then holds that value and does not wrap until the next trigger.
- R7: Status bits stay set until status (address 5) is read with `reg_rd` high. The read clears them all on the next edge, but an event on that same edge stays set.
- R8: `irq` is high exactly when some status bit and its matching enable bit (address 4) are both set.
- R9: While control bit 0 is 0, the count holds and falling edges on `rx_data_in` are ignored: no restart and no status bit.
- R10: A trigger takes priority over a tick in the same cycle. The count is loaded with 0, not with 0 plus one, so a compare value of 0 never matches.
- R11: Each compare A, B or C flag is set only once per run, on the edge where the count becomes equal to its value. After the flag is cleared it stays clear while the count moves beyond that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| carrier_tick | input | 1 | One-cycle carrier clock enable |
| rx_data_in | input | 1 | Asynchronous demodulated receive data, idle high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status at address 5) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from address |
| tx_frame | output | 1 | Transmit-frame start level |
| irq | output | 1 | Interrupt request |

## Verification
The main timing run is driven with a table of compare triples and observation points. The rows cover A before B before C, A beyond C so that A never fires, A equal to B, A equal to C, A at zero, and observation points before, between and exactly at the compare values. Together these separate an off-by-one in the count from a wrong set/clear priority on `tx_frame` and from a missing stop at C. Directed runs then gate `carrier_tick` every other cycle to separate ticks from clock edges. They also disable counting in the middle of a run, send a trigger while disabled, and clear status in the middle of a run to show that a compare passed earlier does not fire again.

// File: rtl/fdt_pkg.sv
package fdt_pkg;

    typedef enum logic {
        ST_STOP = 1'b0,
        ST_RUN  = 1'b1
    } fdt_state_t;

    // number of compare channels and their indices
    localparam int NCMP  = 3;
    localparam int CMP_A = 0;
    localparam int CMP_B = 1;
    localparam int CMP_C = 2;

    // event / status bit positions
    localparam int NEVT    = NCMP + 1;
    localparam int EV_TRIG = 0;

    // register word addresses
    localparam int RA_CTRL   = 0;
    localparam int RA_CMP0   = 1;
    localparam int RA_IEN    = 4;
    localparam int RA_STATUS = 5;
    localparam int RA_COUNT  = 6;

endpackage

// File: rtl/fdt_trig_sync.sv
module fdt_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic fall_pulse
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_in};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign fall_pulse = prev_q & ~sync_q[STAGES-1];

    // R3: an edge yields a one-cycle pulse
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fall_pulse |=> !fall_pulse);

endmodule

// File: rtl/fdt_counter.sv
module fdt_counter
    import fdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       run_en,
    input  logic                       tick,
    input  logic                       trig_fall,
    input  logic [NCMP-1:0][CNT_W-1:0] cmp_vals,
    output logic [CNT_W-1:0]           count,
    output logic                       tx_frame,
    output logic [NEVT-1:0]            events
);
    fdt_state_t       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_nx;
    logic             tx_q;
    logic             trig_ev, step;
    logic [NCMP-1:0]  cmp_hit;

    assign trig_ev  = trig_fall & run_en;
    assign step     = run_en & tick & (state_q == ST_RUN) & ~trig_ev;
    assign count_nx = count_q + {{(CNT_W-1){1'b0}}, 1'b1};

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        assign cmp_hit[g] = step & (count_nx == cmp_vals[g]);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: if (trig_ev) state_d = ST_RUN;
            ST_RUN: begin
                if (trig_ev)             state_d = ST_RUN;
                else if (cmp_hit[CMP_C]) state_d = ST_STOP;
            end
            default: state_d = ST_STOP;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    // count and transmit-frame level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            tx_q    <= 1'b0;
        end else if (trig_ev) begin
            count_q <= '0;
            tx_q    <= 1'b0;
        end else begin
            if (step) count_q <= count_nx;
            if (cmp_hit[CMP_C])      tx_q <= 1'b0;
            else if (cmp_hit[CMP_A]) tx_q <= 1'b1;
        end
    end

    assign count    = count_q;
    assign tx_frame = tx_q;
    assign events   = {cmp_hit, trig_ev};

    // R3: accepted trigger zeroes the count and starts a run
    a_r3_trig_restart: assert property (@(posedge clk) disable iff (!rst_n)
        trig_ev |=> (count_q == '0) && (state_q == ST_RUN));
    // R5: trigger drops the transmit level
    a_r5_trig_clears_tx: assert property (@(posedge clk) disable iff (!rst_n)
        trig_ev |=> !tx_q);
    // R4: the level only rises at compare A
    a_r4_rise_at_a: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_q) |-> (count_q == cmp_vals[CMP_A]));
    // R6: halted counter holds without a trigger
    a_r6_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && !trig_ev) |=> $stable(count_q));
    // R9: disabled counter holds
    a_r9_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(count_q));
    // R2: one step per tick while running
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && run_en && tick && !trig_fall)
        |=> count_q == $past(count_q) + {{(CNT_W-1){1'b0}}, 1'b1});

endmodule

// File: rtl/fdt_regs.sv
module fdt_regs
    import fdt_pkg::*;
#(
    parameter int               CNT_W   = 16,
    parameter int               ADDR_W  = 3,
    parameter logic [CNT_W-1:0] A_RESET = '0,
    parameter logic [CNT_W-1:0] B_RESET = 16'd256,
    parameter logic [CNT_W-1:0] C_RESET = '1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic                       reg_rd,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [CNT_W-1:0]           reg_wdata,
    input  logic [NEVT-1:0]            events,
    input  logic [CNT_W-1:0]           count,
    output logic [CNT_W-1:0]           reg_rdata,
    output logic                       run_en,
    output logic [NCMP-1:0][CNT_W-1:0] cmp_vals,
    output logic                       irq
);
    localparam logic [NCMP-1:0][CNT_W-1:0] CMP_RESET = {C_RESET, B_RESET, A_RESET};

    logic                       en_q;
    logic [NEVT-1:0]            ien_q, status_q;
    logic [NCMP-1:0][CNT_W-1:0] cmp_q;
    logic                       rd_status;
    logic                       unused_wbits;

    assign unused_wbits = ^reg_wdata[CNT_W-1:NEVT];
    assign rd_status    = reg_rd && (reg_addr == ADDR_W'(RA_STATUS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            ien_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_W'(RA_CTRL)) en_q  <= reg_wdata[0];
            if (reg_addr == ADDR_W'(RA_IEN))  ien_q <= reg_wdata[NEVT-1:0];
        end
    end

    for (genvar g = 0; g < NCMP; g++) begin : g_cmpreg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cmp_q[g] <= CMP_RESET[g];
            else if (reg_wr && reg_addr == ADDR_W'(RA_CMP0 + g))
                cmp_q[g] <= reg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (rd_status ? '0 : status_q) | events;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(RA_CTRL):   reg_rdata[0] = en_q;
            ADDR_W'(RA_IEN):    reg_rdata[NEVT-1:0] = ien_q;
            ADDR_W'(RA_STATUS): reg_rdata[NEVT-1:0] = status_q;
            ADDR_W'(RA_COUNT):  reg_rdata = count;
            default: begin
                for (int i = 0; i < NCMP; i++)
                    if (reg_addr == ADDR_W'(RA_CMP0 + i)) reg_rdata = cmp_q[i];
            end
        endcase
    end

    assign run_en   = en_q;
    assign cmp_vals = cmp_q;
    assign irq      = |(status_q & ien_q);

    // R7: a read with no new event leaves status empty
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && events == '0) |=> status_q == '0);
    // R7: without a read no flag is lost
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_status |=> ((status_q & $past(status_q)) == $past(status_q)));

endmodule

// File: rtl/frame_delay_timer.sv
module frame_delay_timer
    import fdt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              carrier_tick,
    input  logic              rx_data_in,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              tx_frame,
    output logic              irq
);
    logic                       trig_fall;
    logic                       run_en;
    logic [NCMP-1:0][CNT_W-1:0] cmp_vals;
    logic [CNT_W-1:0]           count;
    logic [NEVT-1:0]            events;

    fdt_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (rx_data_in),
        .fall_pulse (trig_fall)
    );

    fdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .tick      (carrier_tick),
        .trig_fall (trig_fall),
        .cmp_vals  (cmp_vals),
        .count     (count),
        .tx_frame  (tx_frame),
        .events    (events)
    );

    fdt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .events    (events),
        .count     (count),
        .reg_rdata (reg_rdata),
        .run_en    (run_en),
        .cmp_vals  (cmp_vals),
        .irq       (irq)
    );

endmodule

// File: tb/sim_frame_delay_timer.sv
`timescale 1ns/1ps
module sim_frame_delay_timer;
    localparam int NV = 9;
    // {A, B, C, cycles after trigger}
    localparam int VEC [NV][4] = '{
        '{5, 10, 20, 3}, '{5, 10, 20, 7}, '{5, 10, 20, 12}, '{5, 10, 20, 20},
        '{8, 4, 6, 6},   '{9, 9, 30, 9},  '{12, 3, 12, 12}, '{1, 40, 50, 1},
        '{0, 2, 4, 4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        carrier_tick = 1'b1;
    logic        rx_data_in = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        tx_frame, irq;
    int          n_chk = 0, n_fail = 0;
    logic [15:0] v;

    always #4 clk = ~clk;

    frame_delay_timer u0 (
        .clk(clk), .rst_n(rst_n), .carrier_tick(carrier_tick), .rx_data_in(rx_data_in),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tx_frame(tx_frame), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        reg_addr = 3'(a); reg_wdata = 16'(d); reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(input int a, output logic [15:0] d);
        reg_addr = 3'(a);
        #1 d = reg_rdata;
    endtask

    task automatic rd_clr(output logic [15:0] d);
        reg_addr = 3'd5; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic fire();
        rx_data_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rx_data_in = 1'b1;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int exp_flags(input int a, input int b, input int c, input int k);
        int cnt;
        int f;
        cnt = (k < c) ? k : c;
        f = 1;
        if (a != 0 && a <= cnt) f |= 2;
        if (b != 0 && b <= cnt) f |= 4;
        if (c != 0 && c <= k)   f |= 8;
        return f;
    endfunction

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);
        // R1 reset state
        peek(6, v); chk("R1 count", int'(v), 0);
        chk("R1 tx_frame", int'(tx_frame), 0);
        chk("R1 irq", int'(irq), 0);
        peek(2, v); chk("R1 cmp B", int'(v), 256);
        peek(3, v); chk("R1 cmp C", int'(v), 65535);
        peek(5, v); chk("R1 status", int'(v), 0);
        wait_cyc(3);
        peek(6, v); chk("R1 stopped after reset", int'(v), 0);

        wr(0, 1);
        // table of runs: R2 R3 R4 R5 R6 R10
        for (int i = 0; i < NV; i++) begin
            int a, b, c, k, f;
            a = VEC[i][0]; b = VEC[i][1]; c = VEC[i][2]; k = VEC[i][3];
            wr(1, a); wr(2, b); wr(3, c);
            rd_clr(v);
            fire();
            wait_cyc(k);
            f = exp_flags(a, b, c, k);
            peek(6, v); chk($sformatf("R2 R6 count row %0d", i), int'(v), (k < c) ? k : c);
            chk($sformatf("R4 R5 tx_frame row %0d", i), int'(tx_frame), ((f & 2) != 0 && (f & 8) == 0) ? 1 : 0);
            rd_clr(v); chk($sformatf("R3 R10 R11 status row %0d", i), int'(v), f);
            wait_cyc(c - k + 2);
        end

        // R3: rising edge does nothing, falling edge restarts
        wr(1, 50); wr(2, 60); wr(3, 100);
        rd_clr(v);
        rx_data_in = 1'b0; wait_cyc(6);
        rd_clr(v);
        rx_data_in = 1'b1; wait_cyc(6);
        peek(5, v); chk("R3 rising edge ignored", int'(v), 0);
        rx_data_in = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        peek(6, v); chk("R3 not yet restarted after two edges", (v > 16'd2) ? 1 : 0, 1);
        @(negedge clk);
        peek(6, v); chk("R3 restart on third edge", int'(v), 0);
        rx_data_in = 1'b1;

        // R2: tick gating
        for (int i = 0; i < 10; i++) begin
            carrier_tick = i[0];
            @(negedge clk);
        end
        peek(6, v); chk("R2 count follows ticks", int'(v), 5);
        carrier_tick = 1'b1;

        // R9: disable mid-run
        wr(0, 0);
        peek(6, v); chk("R9 last step before disable", int'(v), 6);
        wait_cyc(7);
        peek(6, v); chk("R9 hold while disabled", int'(v), 6);
        rd_clr(v);
        rx_data_in = 1'b0; wait_cyc(5);
        rx_data_in = 1'b1; wait_cyc(4);
        peek(6, v); chk("R9 trigger ignored count", int'(v), 6);
        peek(5, v); chk("R9 trigger ignored flag", int'(v), 0);
        wr(0, 1);
        wait_cyc(100);

        // R8 and R11 and R6
        wr(1, 50); wr(2, 3); wr(3, 30); wr(4, 4);
        rd_clr(v);
        fire();
        chk("R8 irq masked trigger", int'(irq), 0);
        wait_cyc(3);
        chk("R8 irq on enabled B", int'(irq), 1);
        rd_clr(v); chk("R7 flags held", int'(v), 5);
        chk("R8 irq low after clear", int'(irq), 0);
        wait_cyc(14);
        peek(5, v); chk("R11 no second B match", int'(v), 0);
        peek(6, v); chk("R11 count moved on", int'(v), 18);
        wr(4, 0);
        wait_cyc(15);
        peek(5, v); chk("R6 C flag", int'(v), 8);
        chk("R8 irq masked C", int'(irq), 0);
        peek(6, v); chk("R6 stopped at C", int'(v), 30);
        wait_cyc(10);
        peek(6, v); chk("R6 no wrap", int'(v), 30);
        wr(4, 8);
        chk("R8 irq when enable set", int'(irq), 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule